// File: doc/BRIEF.md
# Two-Pole Cascaded Low-Pass Filter, Two Samples per Clock

The block is a low-pass filter made of two identical first-order recursive sections in series. Each section has a coefficient a = 2^-SHIFT, applied with shifts only. A plain serial form of such a section updates its state once per sample, so the feedback loop has to settle within one sample period. Here each section is restructured in two ways. First, the recursion is rewritten so that the new state depends on the state two samples earlier. Second, the hardware is doubled so that every clock takes in one pair of samples and returns one pair of results. This doubles the sample rate while the clock rate stays the same.

Each clock may carry one input pair, qualified by a valid strobe. Lane 0 holds the earlier sample of the pair and lane 1 the later one. The filtered pair leaves two clocks later from the second section, with its own valid flag.

The results are bit-identical to a serial reference filter, and so is every intermediate value. That reference has these properties:

- Its state is a signed value with FB fractional bits.
- At each sample it computes `s <- s - floor(s / 2^SHIFT) + floor(u / 2^SHIFT)`.
- The first section is fed u = x · 2^FB.
- The second section is fed the first section's new state.
- The output sample is `floor(s2 / 2^FB)`.

The defaults are SHIFT = 3 and FB = 3.

Top module: `lafilt_top`

## Requirements
- R1: While reset is asserted and directly after it is released, out_valid is 0 and out_y0 and out_y1 are 0. Both filter states and the stored previous input start at zero.
- R2: out_valid equals in_valid delayed by exactly two clocks. A pair accepted at clock edge N appears at the outputs after edge N+1.
- R3: For every accepted pair, out_y0 equals the serial reference output for the earlier sample and out_y1 equals it for the later sample. The reference is defined in the description above with a = 1/8 and FB = 3, and it processes the samples in order, lane 0 before lane 1.
- R4: A clock with in_valid low changes neither the filter state nor the outputs. out_y0 and out_y1 hold their last values, and the next valid pair continues the recursion as if no gap had occurred.
- R5: A constant input x held long enough brings both output lanes to exactly x. This holds at the extremes +4095 and -4096.
- R6: After a single nonzero sample followed by zero samples, the outputs return to exactly 0.
- R7: No section state leaves the signed range of DW+FB bits, for any input sequence, including alternating full-scale inputs. The outputs therefore never wrap.
- R8: Lane 1 is the result of one more serial step after lane 0. In each section, the lane 1 state equals one serial step applied to the new lane 0 state with the lane 1 input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The input pair is valid this clock |
| in_x0 | input | DW | Earlier input sample of the pair, signed |
| in_x1 | input | DW | Later input sample of the pair, signed |
| out_valid | output | 1 | The output pair is valid |
| out_y0 | output | DW | Filtered earlier sample, signed |
| out_y1 | output | DW | Filtered later sample, signed |

## Verification
The hardest case to reach is a lane 0 result after an idle gap. Lane 0 depends on the lane 1 input of the previous pair and on the lane 0 state of the previous pair. If either is updated during an idle clock, or taken from the wrong pair, the error only shows once valid pairs resume.

The stimulus therefore mixes bursts of pseudo-random pairs with random idle gaps, and a scoreboard checks every output against a serial model. Full-scale steps in both directions and an impulse followed by a long zero tail push the floor rounding to its limits, with the state at the edge of its range and near zero.

// File: rtl/lafilt_pkg.sv
package lafilt_pkg;

  // One serial update: s - floor(s/2^sh) + floor(u/2^sh), on 32-bit signed values.
  function automatic logic signed [31:0] lp_step(input logic signed [31:0] s,
                                                 input logic signed [31:0] u,
                                                 input int unsigned sh);
    return s - (s >>> sh) + (u >>> sh);
  endfunction

  // Two-sample look-ahead: new state from the state two samples back and the
  // two inputs in order. The inner floor is kept so the result matches serial.
  function automatic logic signed [31:0] lp_look2(input logic signed [31:0] s,
                                                  input logic signed [31:0] u_early,
                                                  input logic signed [31:0] u_late,
                                                  input int unsigned sh);
    logic signed [31:0] mid;
    mid = lp_step(s, u_early, sh);
    return lp_step(mid, u_late, sh);
  endfunction

endpackage

// File: rtl/lafilt_stage.sv
module lafilt_stage
  import lafilt_pkg::*;
#(
  parameter int          SW     = 17,
  parameter int unsigned SHIFT  = 3,
  parameter int          RANGEW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [SW-1:0] in_u0,
  input  logic signed [SW-1:0] in_u1,
  output logic                 out_valid,
  output logic signed [SW-1:0] out_s0,
  output logic signed [SW-1:0] out_s1
);

  localparam int LIM_HI = (1 << (RANGEW - 1)) - 1;
  localparam int LIM_LO = -(1 << (RANGEW - 1));

  function automatic logic signed [31:0] ext(input logic signed [SW-1:0] v);
    return 32'(v);
  endfunction

  logic signed [SW-1:0] s0_q, s1_q, u1_prev_q;
  logic signed [SW-1:0] s0_nxt, s1_nxt;
  logic                 vld_q;

  // Lane 0: state from three samples back, inputs x(k-2) then x(k-1).
  // Lane 1: state from two samples back, inputs x(k-1) then x(k).
  always_comb begin
    s0_nxt = SW'(lp_look2(ext(s0_q), ext(u1_prev_q), ext(in_u0), SHIFT));
    s1_nxt = SW'(lp_look2(ext(s1_q), ext(in_u0), ext(in_u1), SHIFT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q      <= '0;
      s1_q      <= '0;
      u1_prev_q <= '0;
      vld_q     <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        s0_q      <= s0_nxt;
        s1_q      <= s1_nxt;
        u1_prev_q <= in_u1;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_s0    = s0_q;
  assign out_s1    = s1_q;

  // R4: idle clocks leave the state untouched
  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(s0_q) && $stable(s1_q)));

  // R8: the lane 1 look-ahead agrees with one serial step after lane 0
  a_r8_lane_serial: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (s1_q == SW'(lp_step(ext(s0_q), ext($past(in_u1)), SHIFT))));

  // R7: states stay inside the signed DW+FB range
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (ext(s0_q) <= LIM_HI) && (ext(s0_q) >= LIM_LO) &&
    (ext(s1_q) <= LIM_HI) && (ext(s1_q) >= LIM_LO));

endmodule

// File: rtl/lafilt_top.sv
module lafilt_top
  import lafilt_pkg::*;
#(
  parameter int          DW    = 13,
  parameter int          FB    = 3,
  parameter int unsigned SHIFT = 3,
  parameter int          NSTG  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_x0,
  input  logic signed [DW-1:0] in_x1,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_y0,
  output logic signed [DW-1:0] out_y1
);

  localparam int RANGEW = DW + FB;
  localparam int SW     = RANGEW + 1;

  logic                 vld  [0:NSTG];
  logic signed [SW-1:0] lane0[0:NSTG];
  logic signed [SW-1:0] lane1[0:NSTG];

  // Scale the inputs into the fixed-point state domain.
  assign vld[0]   = in_valid;
  assign lane0[0] = SW'(in_x0) <<< FB;
  assign lane1[0] = SW'(in_x1) <<< FB;

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    lafilt_stage #(
      .SW    (SW),
      .SHIFT (SHIFT),
      .RANGEW(RANGEW)
    ) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (vld[g]),
      .in_u0    (lane0[g]),
      .in_u1    (lane1[g]),
      .out_valid(vld[g+1]),
      .out_s0   (lane0[g+1]),
      .out_s1   (lane1[g+1])
    );
  end

  logic signed [SW-1:0] sc0, sc1;
  assign sc0       = lane0[NSTG] >>> FB;
  assign sc1       = lane1[NSTG] >>> FB;
  assign out_y0    = DW'(sc0);
  assign out_y1    = DW'(sc1);
  assign out_valid = vld[NSTG];

  // R2: output valid trails input valid by two clocks
  a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, 2));

  // R1: no output pair is flagged before any input pair was accepted
  a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid, 2));

endmodule

// File: tb/tb_lafilt_top.sv
module tb_lafilt_top;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic signed [12:0] in_x0 = '0;
  logic signed [12:0] in_x1 = '0;
  logic              out_valid;
  logic signed [12:0] out_y0, out_y1;

  lafilt_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_x0(in_x0), .in_x1(in_x1),
    .out_valid(out_valid), .out_y0(out_y0), .out_y1(out_y1)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int m1    = 0;   // reference state, first section
  int m2    = 0;   // reference state, second section
  int q0[$];
  int q1[$];
  int qc[$];
  logic [31:0] seed = 32'h1234_5678;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // floor(v/8) written with division, independent of shifts
  function automatic int floor8(input int v);
    if (v >= 0) return v / 8;
    return -((-v + 7) / 8);
  endfunction

  task automatic model_sample(input int x, output int y);
    m1 = m1 - floor8(m1) + floor8(x * 8);
    m2 = m2 - floor8(m2) + floor8(m1);
    y  = floor8(m2);
  endtask

  task automatic send(input int x0, input int x1);
    int e0, e1;
    @(negedge clk);
    in_valid = 1'b1;
    in_x0    = 13'(x0);
    in_x1    = 13'(x1);
    model_sample(x0, e0);
    model_sample(x1, e1);
    q0.push_back(e0);
    q1.push_back(e1);
    qc.push_back(cyc);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_x0    = 13'h0AAA;
      in_x1    = 13'h1555;
    end
  endtask

  task automatic drain();
    while (q0.size() != 0) idle(1);
    idle(1);
  endtask

  function automatic int rnd13();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'($signed(seed[28:16]));
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q0.size() == 0) begin
        check(1'b0, "R2 unexpected out_valid", 1, 0);
      end else begin
        int e0, e1, c0;
        e0 = q0.pop_front();
        e1 = q1.pop_front();
        c0 = qc.pop_front();
        check(cyc == c0 + 2, "R2 latency", cyc - c0, 2);
        check(int'(out_y0) == e0, "R3 lane0", int'(out_y0), e0);
        check(int'(out_y1) == e1, "R3 lane1", int'(out_y1), e1);
      end
    end
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int h0, h1;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
    check(out_y0 == 0, "R1 y0 in reset", int'(out_y0), 0);
    rst_n = 1'b1;
    idle(2);
    check(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
    check(out_y1 == 0, "R1 y1 after reset", int'(out_y1), 0);

    // R5: positive full-scale step
    for (int i = 0; i < 60; i++) send(4095, 4095);
    drain();
    check(int'(out_y0) == 4095, "R5 pos step lane0", int'(out_y0), 4095);
    check(int'(out_y1) == 4095, "R5 pos step lane1", int'(out_y1), 4095);

    // R5 / R7: negative full-scale step from the positive extreme
    for (int i = 0; i < 60; i++) send(-4096, -4096);
    drain();
    check(int'(out_y0) == -4096, "R5 neg step lane0", int'(out_y0), -4096);
    check(int'(out_y1) == -4096, "R5 neg step lane1", int'(out_y1), -4096);

    // R7: alternating full scale, checked against the model
    for (int i = 0; i < 40; i++) send(4095, -4096);
    for (int i = 0; i < 40; i++) send(-4096, 4095);
    drain();

    // R6: impulse in lane 1 then zeros
    for (int i = 0; i < 80; i++) send(0, 0);
    send(0, 3000);
    for (int i = 0; i < 100; i++) send(0, 0);
    drain();
    check(out_y0 == 0, "R6 impulse tail lane0", int'(out_y0), 0);
    check(out_y1 == 0, "R6 impulse tail lane1", int'(out_y1), 0);

    // R6: negative impulse in lane 0
    send(-2500, 0);
    for (int i = 0; i < 100; i++) send(0, 0);
    drain();
    check(out_y1 == 0, "R6 neg impulse tail", int'(out_y1), 0);

    // R3 / R4: random pairs with random idle gaps
    for (int i = 0; i < 400; i++) begin
      int a, b;
      a = rnd13();
      b = rnd13();
      send(a, b);
      if (seed[5:4] == 2'b00) idle(int'(seed[8:6]) + 1);
    end
    drain();

    // R4: hold during a long idle stretch
    h0 = int'(out_y0);
    h1 = int'(out_y1);
    idle(6);
    check(out_valid == 1'b0, "R4 idle valid", int'(out_valid), 0);
    check(int'(out_y0) == h0, "R4 hold lane0", int'(out_y0), h0);
    check(int'(out_y1) == h1, "R4 hold lane1", int'(out_y1), h1);

    // R4: the recursion continues correctly after the gap
    send(1234, -777);
    send(-3, 5);
    drain();
    check(q0.size() == 0, "R2 all results returned", q0.size(), 0);
    finish_run();
  end

endmodule